// File: doc/BRIEF.md
# Lockable Paged Memory with Commit

This block is the storage backend behind a serial register port. It holds a 96-byte array split into two 48-byte regions, each of which can be write-protected on its own. Byte writes from the port do not go straight into the array. They collect in a 16-byte page buffer, and each buffer entry carries a valid bit. When the port signals that a write transaction has ended, the buffered bytes are programmed into the array. Programming takes a fixed number of cycles, which models the slow cells.

A lock register sits at address 0x70 and has one bit per region. If a commit targets a locked region, the block drops the buffered bytes and raises a sticky protection error. Reads are combinational and can reach any array byte and the lock register. The port can therefore walk through consecutive addresses and receive one byte per cycle.

Top module: `lockable_page_mem`

## Requirements
- R1: After reset, every array byte reads 0x00, the lock register reads 0x00, and busy_o and wp_err_o are low.
- R2: A staged byte does not appear on rdata_o before its commit has finished. While busy_o is high, the array keeps its old contents. The new bytes can be read in the first cycle after busy_o falls.
- R3: A commit accepted at a clock edge drives busy_o high for exactly PROG_CYCLES cycles, starting in the cycle after that edge. The default is 8.
- R4: A commit writes only the offsets that were staged. All other bytes of the same page keep their old values.
- R5: The first staged write fixes the page as address bits [7:4]. Until the next commit or discard, any write to a different page is ignored. Writes to addresses 0x60..0xFF are also ignored, except for the lock register at 0x70.
- R6: A write strobe is ignored in any cycle where busy_o or commit_i is high.
- R7: Writing 0x70 updates the lock register at once. Bit 0 protects bytes 0x00..0x2F and bit 1 protects bytes 0x30..0x5F. Reading 0x70 returns the two lock bits in bits [1:0], with the upper bits zero. The lock bits change only through a write to 0x70.
- R8: A commit whose staged page lies in a locked region behaves as follows:
  - it leaves busy_o low;
  - it leaves the array unchanged;
  - it discards the staged bytes;
  - it sets wp_err_o, which then stays high until reset.
- R9: Every commit clears all staged entries. A commit with nothing staged leaves busy_o low and the array unchanged.
- R10: rdata_o shows the byte at raddr_i in the same cycle, for any array address, whether or not that address is locked. It reads 0x00 for addresses 0x60..0xFF other than 0x70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Write address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| raddr_i | input | 8 | Read address |
| rdata_o | output | 8 | Read data, combinational from raddr_i |
| commit_i | input | 1 | End-of-write pulse that starts programming |
| busy_o | output | 1 | High while the array is being programmed |
| wp_err_o | output | 1 | Sticky flag: a commit hit a locked region |

## Verification
The main commit path is tried with three input patterns:
- A contiguous run of bytes. This shows the timing of programming.
- A sparse set of offsets within one page. This shows whether untouched offsets stay as they were.
- A mix of writes in the right page, the wrong page and out of range. This shows whether the page tag and the range gate filter writes correctly.

Commits are also issued in several other conditions:
- with nothing staged;
- right after a blocked commit;
- with strobes arriving during busy.

Each of these must produce no busy period, which shows that the valid bits are cleared and that strobes are ignored.

The two lock bits are set one at a time. A commit is sent to both regions under each setting, so the bench can tell whether each bit protects its own region only.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/lpm_page_buf.sv
module lpm_page_buf
  import lpm_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int PAGE_IDX_W = 3,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [PAGE_IDX_W-1:0]       page_i,
  input  logic [OFF_W-1:0]            off_i,
  input  byte_t                       wdata_i,
  input  logic                        clear_i,
  input  logic                        hold_i,
  output logic [PAGE_BYTES-1:0]       valid_o,
  output logic [PAGE_BYTES-1:0][7:0]  data_o,
  output logic [PAGE_IDX_W-1:0]       tag_o,
  output logic                        any_o
);
  logic [PAGE_BYTES-1:0]      valid_q;
  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PAGE_IDX_W-1:0]      tag_q;
  logic                       accept;

  assign any_o  = |valid_q;
  // first staged byte fixes the page; later bytes must match it
  assign accept = wr_i && (!any_o || page_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      data_q  <= '0;
      tag_q   <= '0;
    end else if (clear_i) begin
      valid_q <= '0;
    end else if (accept) begin
      valid_q[off_i] <= 1'b1;
      data_q[off_i]  <= wdata_i;
      if (!any_o) tag_q <= page_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign tag_o   = tag_q;

  p_clear_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_q == '0));
  p_hold_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i) |=> $stable(valid_q));
  p_tag_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |=> (!any_o || $stable(tag_q)));
endmodule

// File: rtl/lpm_lock_ctrl.sv
module lpm_lock_ctrl #(
  parameter int N_REGIONS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [N_REGIONS-1:0] wdata_i,
  output logic [N_REGIONS-1:0] lock_o
);
  logic [N_REGIONS-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_q <= '0;
    else if (wr_i) lock_q <= wdata_i;
  end

  assign lock_o = lock_q;

  p_lock_only_by_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(lock_o));
endmodule

// File: rtl/lpm_prog_timer.sv
module lpm_prog_timer #(
  parameter int PROG_CYCLES = 8,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= CNT_W'(PROG_CYCLES);
    else if (busy_o)             cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  p_busy_runs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  p_done_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_start_raises_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/lockable_page_mem.sv
module lockable_page_mem
  import lpm_pkg::*;
#(
  parameter int MEM_BYTES    = 96,
  parameter int REGION_BYTES = 48,
  parameter int PAGE_BYTES   = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             wdata_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              wp_err_o
);
  localparam int N_REGIONS        = MEM_BYTES / REGION_BYTES;
  localparam int PAGES            = MEM_BYTES / PAGE_BYTES;
  localparam int PAGES_PER_REGION = REGION_BYTES / PAGE_BYTES;
  localparam int OFF_W            = $clog2(PAGE_BYTES);
  localparam int PAGE_IDX_W       = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int MEM_IDX_W        = $clog2(MEM_BYTES);

  logic                        in_mem, is_lock, wr_ok, commit_ok;
  logic                        busy, prog_done, prog_start, prot_hit, locked;
  logic [PAGE_BYTES-1:0]       buf_valid;
  logic [PAGE_BYTES-1:0][7:0]  buf_data;
  logic [PAGE_IDX_W-1:0]       buf_tag, addr_page;
  logic                        buf_any;
  logic [N_REGIONS-1:0]        lock_q;
  logic                        err_q;
  byte_t                       mem_q [MEM_BYTES];

  assign in_mem    = (addr_i < ADDR_W'(MEM_BYTES));
  assign is_lock   = (addr_i == LOCK_ADDR);
  assign wr_ok     = wr_i && !busy && !commit_i;
  assign commit_ok = commit_i && !busy;
  assign addr_page = PAGE_IDX_W'(addr_i >> OFF_W);

  lpm_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_IDX_W (PAGE_IDX_W)
  ) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok && in_mem),
    .page_i  (addr_page),
    .off_i   (addr_i[OFF_W-1:0]),
    .wdata_i (wdata_i),
    .clear_i (prot_hit || prog_done),
    .hold_i  (busy),
    .valid_o (buf_valid),
    .data_o  (buf_data),
    .tag_o   (buf_tag),
    .any_o   (buf_any)
  );

  lpm_lock_ctrl #(
    .N_REGIONS (N_REGIONS)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ok && is_lock),
    .wdata_i (wdata_i[N_REGIONS-1:0]),
    .lock_o  (lock_q)
  );

  // pages never straddle a region boundary
  always_comb begin
    locked = 1'b0;
    for (int r = 0; r < N_REGIONS; r++)
      if (int'(buf_tag) / PAGES_PER_REGION == r) locked = lock_q[r];
  end

  assign prog_start = commit_ok && buf_any && !locked;
  assign prot_hit   = commit_ok && buf_any && locked;

  lpm_prog_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .busy_o  (busy),
    .done_o  (prog_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (prot_hit) err_q <= 1'b1;
  end

  for (genvar b = 0; b < MEM_BYTES; b++) begin : g_cell
    localparam int PG  = b / PAGE_BYTES;
    localparam int OFF = b % PAGE_BYTES;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[b] <= '0;
      else if (prog_done && buf_tag == PAGE_IDX_W'(PG) && buf_valid[OFF])
        mem_q[b] <= buf_data[OFF];
    end
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prog_done |=> $stable(mem_q[b]));
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i < ADDR_W'(MEM_BYTES)) rdata_o = mem_q[raddr_i[MEM_IDX_W-1:0]];
    else if (raddr_i == LOCK_ADDR)    rdata_o = {{(8-N_REGIONS){1'b0}}, lock_q};
  end

  assign busy_o   = busy;
  assign wp_err_o = err_q;

  p_locked_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_hit |=> (!busy_o && wp_err_o));
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_err_o |=> wp_err_o);
  p_empty_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_ok && !buf_any) |=> !busy_o);
endmodule

// File: tb/lockable_page_mem_tb.sv
module lockable_page_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 8;

  logic       clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, raddr = 0, rdata;
  logic       wr = 0, commit = 0, busy, wp_err;

  int compared = 0, mismatched = 0;

  typedef struct { logic [7:0] a; logic [7:0] e; string tag; } rd_item_t;
  rd_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lockable_page_mem #(.PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .raddr_i(raddr), .rdata_o(rdata), .commit_i(commit), .busy_o(busy),
    .wp_err_o(wp_err)
  );

  // monitor: pops expected reads and compares
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      compared++;
      if (rdata !== it.e) begin
        mismatched++;
        $display("FAIL %s: read 0x%02h got 0x%02h expected 0x%02h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    raddr = a;
    it.a = a; it.e = e; it.tag = tag;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic pulse_commit();
    @(posedge clk); #1; commit = 1;
    @(posedge clk); #1; commit = 0;
  endtask

  task automatic commit_count(output int n);
    pulse_commit();
    n = 0;
    for (int k = 0; k < 3*PROG + 4; k++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy, 0, "R1 busy");
    chk(wp_err, 0, "R1 wp_err");
    exp_rd(8'h00, 8'h00, "R1");
    exp_rd(8'h5F, 8'h00, "R1");
    exp_rd(8'h70, 8'h00, "R1 lock");

    // R2/R3: contiguous run
    wr_byte(8'h10, 8'hA1);
    wr_byte(8'h11, 8'hA2);
    wr_byte(8'h12, 8'hA3);
    exp_rd(8'h10, 8'h00, "R2 before commit");
    @(posedge clk); #1 raddr = 8'h10;
    pulse_commit();
    @(negedge clk);
    chk(busy, 1, "R3 busy after commit");
    chk(rdata, 8'h00, "R2 during busy");
    n = 1;
    for (int k = 0; k < 3*PROG; k++) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk(n, PROG, "R3 busy length");
    exp_rd(8'h10, 8'hA1, "R2 after commit");
    exp_rd(8'h11, 8'hA2, "R10 consecutive");
    exp_rd(8'h12, 8'hA3, "R10 consecutive");
    exp_rd(8'h13, 8'h00, "R4 unstaged");
    exp_rd(8'h0F, 8'h00, "R4 other page");

    // R4 sparse offsets
    wr_byte(8'h52, 8'h01);
    wr_byte(8'h5E, 8'h02);
    commit_count(n);
    chk(n, PROG, "R3 second commit");
    exp_rd(8'h52, 8'h01, "R4");
    exp_rd(8'h5E, 8'h02, "R4");
    exp_rd(8'h53, 8'h00, "R4 gap");

    // R5 page tag and range gate
    wr_byte(8'h20, 8'h55);
    wr_byte(8'h31, 8'h66);
    wr_byte(8'h62, 8'h77);
    commit_count(n);
    exp_rd(8'h20, 8'h55, "R5 tag page");
    exp_rd(8'h31, 8'h00, "R5 foreign page");
    exp_rd(8'h62, 8'h00, "R10 out of range");

    // R6 strobes during busy and commit cycle
    wr_byte(8'h40, 8'h11);
    pulse_commit();
    @(posedge clk); #1;
    addr = 8'h41; wdata = 8'h22; wr = 1;
    @(posedge clk); #1; wr = 0;
    wait (!busy);
    exp_rd(8'h40, 8'h11, "R6 staged byte");
    exp_rd(8'h41, 8'h00, "R6 busy strobe");
    commit_count(n);
    chk(n, 0, "R6 busy strobe not staged");
    @(posedge clk); #1;
    addr = 8'h42; wdata = 8'h33; wr = 1; commit = 1;
    @(posedge clk); #1; wr = 0; commit = 0;
    @(negedge clk);
    chk(busy, 0, "R6 commit-cycle strobe");
    commit_count(n);
    chk(n, 0, "R6 commit-cycle strobe not staged");

    // R9 empty commit
    commit_count(n);
    chk(n, 0, "R9 empty commit");

    // R7/R8 lock region 0
    wr_byte(8'h70, 8'h01);
    exp_rd(8'h70, 8'h01, "R7 lock read");
    wr_byte(8'h05, 8'h99);
    commit_count(n);
    chk(n, 0, "R8 blocked no busy");
    chk(wp_err, 1, "R8 err set");
    exp_rd(8'h05, 8'h00, "R8 array unchanged");
    wr_byte(8'h35, 8'hBB);
    commit_count(n);
    chk(n, PROG, "R7 region1 open");
    exp_rd(8'h35, 8'hBB, "R7 region1 write");
    chk(wp_err, 1, "R8 err sticky");

    // R7 lock region 1 only
    wr_byte(8'h70, 8'h02);
    exp_rd(8'h70, 8'h02, "R7 lock read");
    wr_byte(8'h06, 8'hCC);
    commit_count(n);
    chk(n, PROG, "R7 region0 open");
    exp_rd(8'h06, 8'hCC, "R7 region0 write");
    wr_byte(8'h5F, 8'hDD);
    commit_count(n);
    chk(n, 0, "R8 region1 blocked");
    exp_rd(8'h5F, 8'h00, "R8 array unchanged");
    exp_rd(8'h35, 8'hBB, "R10 read locked region");
    exp_rd(8'h71, 8'h00, "R10 unmapped");

    // R8 discarded bytes do not return after unlock
    wr_byte(8'h70, 8'h00);
    exp_rd(8'h70, 8'h00, "R7 unlock");
    commit_count(n);
    chk(n, 0, "R8 staged bytes discarded");
    exp_rd(8'h5F, 8'h00, "R8 discarded");
    chk(wp_err, 1, "R8 err sticky");

    finish_run();
  end
endmodule